// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital edge of one voice channel on a shared time-division PCM highway. The highway runs a bit clock; 2.048 MHz gives 256 bit clocks in a 125 µs frame. A frame-sync strobe marks the start of this channel's time slot. After each strobe the port drives one sample byte onto the shared serial line, one bit per bit clock, and captures one byte from the incoming serial line in the same eight clocks. For the rest of the frame it releases the line so that other channels can use it.

The sample source writes a new transmit byte at any time through a parallel load strobe. That byte waits in a holding register and leaves only at the next frame sync. It never disturbs a byte that is already being shifted. Each received byte appears on a parallel output with a single-cycle valid pulse. The design runs directly on the bit clock, which is the input `clk`.

The control is a two-state machine. `ST_IDLE` is the line-released state. `ST_SHIFT` is the eight-clock window. These transitions exist:
- SYNC_OPEN: `ST_IDLE` to `ST_SHIFT` on a sampled sync.
- WINDOW_CLOSE: `ST_SHIFT` to `ST_IDLE` after the eighth bit, with no sync.
- RESTART: `ST_SHIFT` to `ST_SHIFT` on a sync inside the window.
- IDLE_HOLD: `ST_IDLE` to `ST_IDLE` with no sync.
- SHIFT_HOLD: `ST_SHIFT` to `ST_SHIFT` while bits remain.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `sdo_oe` and `sdo` are 0, `rx_valid` is 0, `rx_data` is 0x00, and the transmit holding register contains IDLE_CODE (default 0xFF). IDLE_CODE is the byte sent if a sync arrives before any load.
- R2: When `fsync` is sampled high at a rising edge, the held byte appears on `sdo` during the next eight clock cycles, most significant bit first, one bit per cycle.
- R3: `sdo_oe` is high during exactly those eight cycles and low otherwise. `sdo` is 0 whenever `sdo_oe` is low.
- R4: `sdi` is sampled at each of the eight rising edges that end the window's bit cycles, first bit as MSB. After the eighth sample, `rx_data` shows the byte and `rx_valid` is high for exactly one cycle.
- R5: `rx_data` keeps its value in every cycle where `rx_valid` is low.
- R6: A `tx_load` pulse changes only the holding register. The byte in flight is unchanged, and the new byte goes out at the next sync. This includes a load on the same edge as a sync, in which case the previously held byte is sent.
- R7: A sync sampled during a window, before the eighth bit is captured, aborts that byte. No `rx_valid` is produced for it. A fresh eight-cycle window starts with the held byte from its MSB.
- R8: A sync on the same edge as the eighth capture completes the byte with its `rx_valid` pulse and opens a new window directly.
- R9: With no new load, every following frame sends the same held byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync strobe for this channel's slot |
| sdi | input | 1 | Serial receive data from the highway |
| tx_data | input | WIDTH | Parallel transmit sample |
| tx_load | input | 1 | Writes tx_data into the holding register |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Drive enable for sdo on the shared line |
| rx_data | output | WIDTH | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
A wrong state or bit count shows up as soon as the first cycle after a sync. The enable then opens a cycle early or late, or stays open past eight cycles, so two channels would drive the line at once. A corrupted shift or holding register shows as a wrong bit on `sdo` within the same window. A wrong receive count shows as a missing, extra or misplaced `rx_valid` at the window's end. A wrong abort or restart decision shows within one window of the early or coinciding sync. The reference model compares all four outputs every cycle, so every divergence is reported in the cycle where it first appears.

// File: rtl/pcm_slot_pkg.sv
`timescale 1ns/1ps
package pcm_slot_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } slot_state_e;
endpackage

// File: rtl/pcm_slot_fsm.sv
`timescale 1ns/1ps
module pcm_slot_fsm
    import pcm_slot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic win_active,
    output logic reload,
    output logic last_bit
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    slot_state_e state_q, state_d;
    logic [CW-1:0] bit_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fsync) state_d = ST_SHIFT;       // SYNC_OPEN
                else       state_d = ST_IDLE;        // IDLE_HOLD
            end
            ST_SHIFT: begin
                if (fsync)                   state_d = ST_SHIFT; // RESTART
                else if (bit_q == LAST_IDX)  state_d = ST_IDLE;  // WINDOW_CLOSE
                else                         state_d = ST_SHIFT; // SHIFT_HOLD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bit position inside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (fsync) begin
            bit_q <= '0;
        end else if (state_q == ST_SHIFT) begin
            bit_q <= (bit_q == LAST_IDX) ? '0 : bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        win_active = 1'b0;
        last_bit   = 1'b0;
        reload     = fsync;
        unique case (state_q)
            ST_IDLE: begin
                win_active = 1'b0;
                last_bit   = 1'b0;
            end
            ST_SHIFT: begin
                win_active = 1'b1;
                last_bit   = (bit_q == LAST_IDX);
            end
            default: begin
                win_active = 1'b0;
                last_bit   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pcm_tx_hold.sv
`timescale 1ns/1ps
module pcm_tx_hold #(
    parameter int          WIDTH     = 8,
    parameter logic [WIDTH-1:0] IDLE_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] held
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= IDLE_CODE;
        end else if (load) begin
            held <= din;
        end
    end
endmodule

// File: rtl/pcm_shift_pair.sv
`timescale 1ns/1ps
module pcm_shift_pair #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             active,
    input  logic             last_bit,
    input  logic [WIDTH-1:0] tx_word,
    input  logic             sdi,
    output logic             tx_msb,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_strobe
);
    logic [WIDTH-1:0] tx_sh;
    logic [WIDTH-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (reload) begin
            tx_sh <= tx_word;
        end else if (active) begin
            tx_sh <= {tx_sh[WIDTH-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (active) begin
            rx_sh <= {rx_sh[WIDTH-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= last_bit;
            if (last_bit) begin
                rx_word <= {rx_sh[WIDTH-2:0], sdi};
            end
        end
    end

    assign tx_msb = tx_sh[WIDTH-1];
endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IDLE_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             sdi,
    input  logic [WIDTH-1:0] tx_data,
    input  logic             tx_load,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [WIDTH-1:0] rx_data,
    output logic             rx_valid
);
    logic             win_active;
    logic             reload;
    logic             last_bit;
    logic             tx_msb;
    logic [WIDTH-1:0] held;

    pcm_slot_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .win_active (win_active),
        .reload     (reload),
        .last_bit   (last_bit)
    );

    pcm_tx_hold #(.WIDTH(WIDTH), .IDLE_CODE(IDLE_CODE)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .din   (tx_data),
        .held  (held)
    );

    pcm_shift_pair #(.WIDTH(WIDTH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .active    (win_active),
        .last_bit  (last_bit),
        .tx_word   (held),
        .sdi       (sdi),
        .tx_msb    (tx_msb),
        .rx_word   (rx_data),
        .rx_strobe (rx_valid)
    );

    assign sdo_oe = win_active;
    assign sdo    = win_active & tx_msb;
endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
module pcm_slot_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync,
    input logic             sdo,
    input logic             sdo_oe,
    input logic [WIDTH-1:0] rx_data,
    input logic             rx_valid
);
    int unsigned win_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      win_cnt <= 0;
        else if (fsync)  win_cnt <= 1;
        else if (sdo_oe) win_cnt <= win_cnt + 1;
        else             win_cnt <= 0;
    end

    AST_SYNC_OPENS: assert property (@(posedge clk) disable iff (!rst_n) fsync |=> sdo_oe); // R3
    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe |-> !sdo); // R3
    AST_OE_RISE_SYNC: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe) |-> $past(fsync)); // R3
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> (win_cnt <= WIDTH)); // R3
    AST_VALID_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $past(sdo_oe)); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R4
    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |-> $stable(rx_data)); // R5
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
);

// File: tb/pcm_slot_port_test.sv
`timescale 1ns/1ps
module pcm_slot_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [W-1:0] IDLE = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic sdi = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic tx_load = 1'b0;
    logic sdo, sdo_oe, rx_valid;
    logic [W-1:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string scen = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_slot_port #(.WIDTH(W), .IDLE_CODE(IDLE)) uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdi(sdi),
        .tx_data(tx_data), .tx_load(tx_load),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // behavioural reference model
    int m_pos = -1;
    logic [W-1:0] m_buf = IDLE;
    logic [W-1:0] m_acc = '0;
    logic [W-1:0] m_rx = '0;
    bit m_valid = 0;
    bit txq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = -1; m_buf = IDLE; m_acc = '0; m_rx = '0; m_valid = 0;
            txq.delete();
        end else begin
            m_valid = 0;
            if (m_pos >= 0) begin
                m_acc = {m_acc[W-2:0], sdi};
                if (txq.size() > 0) void'(txq.pop_front());
                m_pos++;
                if (m_pos == W) begin
                    m_rx = m_acc; m_valid = 1; m_pos = -1;
                end
            end
            if (fsync) begin
                m_pos = 0;
                txq.delete();
                for (int i = W-1; i >= 0; i--) txq.push_back(m_buf[i]);
            end
            if (tx_load) m_buf = tx_data;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t: actual %0h expected %0h", req, scen, $time, act, exp);
        end
    endtask

    task automatic compare();
        bit e_oe, e_sdo;
        e_oe = (m_pos >= 0);
        e_sdo = (e_oe && txq.size() > 0) ? txq[0] : 1'b0;
        chk(sdo_oe === e_oe, "R3", int'(sdo_oe), int'(e_oe));
        chk(sdo === e_sdo, "R2", int'(sdo), int'(e_sdo));
        chk(rx_valid === m_valid, "R4", int'(rx_valid), int'(m_valid));
        chk(rx_data === m_rx, "R5", int'(rx_data), int'(m_rx));
    endtask

    task automatic step(bit fs, bit ld, logic [W-1:0] d);
        @(negedge clk);
        compare();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fsync = fs; tx_load = ld; tx_data = d; sdi = lfsr[0];
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        chk(sdo_oe === 1'b0 && sdo === 1'b0, "R1", int'({sdo_oe, sdo}), 0);
        chk(rx_valid === 1'b0 && rx_data === '0, "R1", int'(rx_data), 0);
        rst_n = 1'b1;
        idle(3);
        scen = "R1"; step(1, 0, '0); idle(20);                 // idle code goes out
        scen = "R2"; step(0, 1, 8'hA5); idle(4);
        step(1, 0, '0); idle(3);
        scen = "R6"; step(0, 1, 8'h3C); idle(20);               // load mid-window
        step(1, 1, 8'h81); idle(24);                             // R6: load on sync edge
        scen = "R9"; step(1, 0, '0); idle(24);                   // R9 resend 81
        step(1, 0, '0); idle(24);
        scen = "R7"; step(0, 1, 8'h5A); step(1, 0, '0); idle(3);
        step(1, 0, '0); idle(20);                                // R7 abort after 4 bits
        scen = "R8"; step(1, 1, 8'hC3); idle(7);
        step(1, 0, '0); idle(7); step(1, 0, '0); idle(20);       // R8 back-to-back windows
        scen = "R4";
        for (int f = 0; f < 6; f++) begin
            step(0, 1, 8'(f * 37 + 11)); idle(5);
            step(1, 0, '0); idle(25);
        end
        idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule